// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects interrupt conditions for a DMA controller with a configurable number of channels (default 12). The channel engines send it single-cycle pulses for three conditions: a block transfer has finished, a transfer error has occurred (a bus error in a burst or an invalid descriptor), and the channel has been suspended. Each pulse latches a per-channel flag. Software clears a flag by writing a one to it. Each channel also has an enable bit for each condition. Software turns enable bits on through a set port and off through a separate clear port, so it never has to read, modify and write them back.

A channel is pending while any of its flags is set together with the matching enable bit. The block outputs a pending vector with one bit per channel and a single combined interrupt line. It also outputs a priority view that gives the lowest-numbered pending channel and that channel's raw flags, so an interrupt handler can find its next job without scanning the vector. A request stays raised until its flag is cleared, its enable is cleared, the channel is reset by its own strobe, or the whole block is reset.

Top module: `dma_irq_agg`

## Requirements
- R1: A one-cycle pulse on a condition input sets that channel's flag at the next clock edge. The flag field of each channel has bit 0 for transfer done, bit 1 for error and bit 2 for suspend. Channel c occupies bits [3c+2:3c] of the flag and enable views.
- R2: A flag-clear write to channel c clears every flag bit whose mask bit is one. Mask bits that are zero leave their flags unchanged.
- R3: When a condition pulse and a flag-clear write hit the same flag at the same edge, the flag ends up set.
- R4: A write to the enable-set port turns on the masked enable bits of the addressed channel. A write to the enable-clear port turns them off. If both ports address the same bit at the same edge, the bit ends up off.
- R5: Bit c of the pending vector is one exactly when channel c has at least one flag whose enable bit is also one.
- R6: The interrupt output is the OR of all bits of the pending vector.
- R7: When any channel is pending, the priority view gives valid=1, the lowest pending channel number, and that channel's three flags.
- R8: When no channel is pending, the priority view gives valid=0, channel 0 and flags 000.
- R9: A channel reset strobe clears that channel's flags and enables at the next edge. It wins over any event or write to that channel at the same edge. Other channels are not affected.
- R10: A synchronous active-low reset clears all flags and enables.
- R11: Clearing an enable bit removes the request but leaves the flag readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| ev_done | input | NUM_CH | Transfer-done pulse, one bit per channel |
| ev_err | input | NUM_CH | Transfer-error pulse, one bit per channel |
| ev_susp | input | NUM_CH | Channel-suspend pulse, one bit per channel |
| ch_rst | input | NUM_CH | Per-channel reset strobe |
| fclr_we | input | 1 | Flag-clear write strobe |
| fclr_ch | input | CH_W | Channel addressed by the flag-clear write |
| fclr_mask | input | 3 | Write-one-to-clear mask for the flags |
| ien_set_we | input | 1 | Enable-set write strobe |
| ien_set_ch | input | CH_W | Channel addressed by the enable-set write |
| ien_set_mask | input | 3 | Enable bits to turn on |
| ien_clr_we | input | 1 | Enable-clear write strobe |
| ien_clr_ch | input | CH_W | Channel addressed by the enable-clear write |
| ien_clr_mask | input | 3 | Enable bits to turn off |
| flag_view | output | 3*NUM_CH | Flags of all channels |
| en_view | output | 3*NUM_CH | Enables of all channels |
| chan_pend | output | NUM_CH | Per-channel pending vector |
| low_valid | output | 1 | Some channel is pending |
| low_ch | output | CH_W | Lowest pending channel |
| low_flags | output | 3 | Flags of the lowest pending channel |
| irq | output | 1 | Combined interrupt request |

## Verification
All state sits in the flag and enable registers, and both are visible on the view outputs one edge after any change. A lost set, a clear that touches the wrong bit, or a missed channel reset therefore shows up at the very next sample. An error in priority selection shows up only when several channels are pending at the same time, so the stimulus keeps lower and higher channels pending together and then removes the lowest one to check that the view moves to the next channel. Because the interrupt line, the valid bit and the pending vector are produced by separate logic, a fault in any one of them appears as a mismatch in the same cycle.

// File: rtl/dma_irq_pkg.sv
// Package: shared widths, source bit positions and the per-channel
// source vector type used by the interrupt aggregator.
package dma_irq_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_DONE = 0;
    localparam int SRC_ERR  = 1;
    localparam int SRC_SUSP = 2;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/dma_irq_wdec.sv
// Write decoder: turns one indexed write (strobe, channel, mask) into
// a per-channel mask bus. Assumes indices at or above NUM_CH address
// nothing and are therefore dropped.
module dma_irq_wdec
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4
) (
    input  logic            we,
    input  logic [CH_W-1:0] ch,
    input  src_vec_t        mask,
    output src_vec_t        per_ch [NUM_CH]
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        // Route the mask only to the addressed channel.
        always_comb per_ch[g] = (we && (ch == CH_W'(g))) ? mask : '0;
    end
endmodule

// File: rtl/dma_irq_chan.sv
// One channel's interrupt state: sticky flags (event set, write-one
// clear) and enables (set/clear ports). Assumes the mask inputs are
// already decoded for this channel. Precedence at an edge: channel
// reset, then event set over software clear, then enable clear over set.
module dma_irq_chan
    import dma_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t ev,
    input  logic     chan_rst,
    input  src_vec_t clr_mask,
    input  src_vec_t en_set,
    input  src_vec_t en_clr,
    output src_vec_t flags,
    output src_vec_t ens,
    output logic     pend
);
    // Flag register: reset, else keep uncleared bits and add new events.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) flags <= '0;
        else                    flags <= (flags & ~clr_mask) | ev;
    end

    // Enable register: reset, else add set bits, then remove clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) ens <= '0;
        else                    ens <= (ens | en_set) & ~en_clr;
    end

    // Channel is pending when an enabled flag is up.
    always_comb pend = |(flags & ens);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_rst && ev != '0) |=> ((flags & $past(ev)) == $past(ev))); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_rst && (clr_mask & ~ev) != '0) |=> ((flags & $past(clr_mask & ~ev)) == '0)); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_rst && ev == '0 && clr_mask == '0) |=> $stable(flags)); // R1
    AST_CHRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (flags == '0 && ens == '0)); // R9
    AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_rst && en_clr != '0) |=> ((ens & $past(en_clr)) == '0)); // R4
endmodule

// File: rtl/dma_irq_prio.sv
// Lowest-index finder over the pending vector. Assumes bit 0 is the
// highest priority. Reports index 0 and valid low when nothing pends.
module dma_irq_prio #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend,
    output logic              valid,
    output logic [CH_W-1:0]   idx
);
    localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

    // Scan from the top down so the lowest pending index is kept last.
    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CH_W'(i);
        end
    end

    // Any channel pending.
    always_comb valid = |pend;

    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pend[idx]); // R7
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((pend & ((ONE << idx) - ONE)) == '0)); // R7
endmodule

// File: rtl/dma_irq_agg.sv
// Interrupt aggregator for an NUM_CH-channel DMA controller. Decodes
// the three indexed write ports, keeps one flag/enable slice per
// channel, and produces pending vector, lowest-pending view and the
// combined request. Assumes all inputs are synchronous to clk.
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 12,
    localparam int CH_W  = $clog2(NUM_CH > 1 ? NUM_CH : 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      ev_done,
    input  logic [NUM_CH-1:0]      ev_err,
    input  logic [NUM_CH-1:0]      ev_susp,
    input  logic [NUM_CH-1:0]      ch_rst,
    input  logic                   fclr_we,
    input  logic [CH_W-1:0]        fclr_ch,
    input  logic [NSRC-1:0]        fclr_mask,
    input  logic                   ien_set_we,
    input  logic [CH_W-1:0]        ien_set_ch,
    input  logic [NSRC-1:0]        ien_set_mask,
    input  logic                   ien_clr_we,
    input  logic [CH_W-1:0]        ien_clr_ch,
    input  logic [NSRC-1:0]        ien_clr_mask,
    output logic [NSRC*NUM_CH-1:0] flag_view,
    output logic [NSRC*NUM_CH-1:0] en_view,
    output logic [NUM_CH-1:0]      chan_pend,
    output logic                   low_valid,
    output logic [CH_W-1:0]        low_ch,
    output logic [NSRC-1:0]        low_flags,
    output logic                   irq
);
    src_vec_t clr_bus [NUM_CH];
    src_vec_t set_bus [NUM_CH];
    src_vec_t off_bus [NUM_CH];
    src_vec_t flg     [NUM_CH];
    src_vec_t ena     [NUM_CH];

    dma_irq_wdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec_fclr (
        .we(fclr_we), .ch(fclr_ch), .mask(fclr_mask), .per_ch(clr_bus));
    dma_irq_wdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec_eset (
        .we(ien_set_we), .ch(ien_set_ch), .mask(ien_set_mask), .per_ch(set_bus));
    dma_irq_wdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec_eclr (
        .we(ien_clr_we), .ch(ien_clr_ch), .mask(ien_clr_mask), .per_ch(off_bus));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        src_vec_t ev_g;
        // Gather this channel's three condition pulses.
        always_comb begin
            ev_g           = '0;
            ev_g[SRC_DONE] = ev_done[g];
            ev_g[SRC_ERR]  = ev_err[g];
            ev_g[SRC_SUSP] = ev_susp[g];
        end

        dma_irq_chan u_chan (
            .clk(clk), .rst_n(rst_n), .ev(ev_g), .chan_rst(ch_rst[g]),
            .clr_mask(clr_bus[g]), .en_set(set_bus[g]), .en_clr(off_bus[g]),
            .flags(flg[g]), .ens(ena[g]), .pend(chan_pend[g]));

        // Flatten the slice into the readable views.
        always_comb begin
            flag_view[NSRC*g +: NSRC] = flg[g];
            en_view[NSRC*g +: NSRC]   = ena[g];
        end
    end

    dma_irq_prio #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(chan_pend), .valid(low_valid), .idx(low_ch));

    // Show the winner's flags, or zero when nothing pends.
    always_comb low_flags = low_valid ? flg[low_ch] : '0;

    // Combined request from the per-channel pending bits.
    always_comb irq = |chan_pend;

    AST_IRQ_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq == low_valid); // R6
    AST_IDLE_VIEW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !low_valid |-> (low_ch == '0 && low_flags == '0)); // R8
    AST_VIEW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        low_valid |-> (low_flags != '0)); // R7
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 12;
    localparam int CW = 4;

    // Row: kind(3) ch(4) mask(3) | exp valid(1) ch(4) flags(3) irq(1)
    // kind 0 event, 1 flag clear, 2 enable set, 3 enable clear, 4 channel reset
    localparam int ROWS = 12;
    localparam logic [18:0] TABLE [ROWS] = '{
        {3'd0, 4'd5,  3'b010, 1'b0, 4'd0,  3'b000, 1'b0},
        {3'd2, 4'd5,  3'b010, 1'b1, 4'd5,  3'b010, 1'b1},
        {3'd0, 4'd9,  3'b001, 1'b1, 4'd5,  3'b010, 1'b1},
        {3'd2, 4'd9,  3'b001, 1'b1, 4'd5,  3'b010, 1'b1},
        {3'd2, 4'd2,  3'b100, 1'b1, 4'd5,  3'b010, 1'b1},
        {3'd0, 4'd2,  3'b100, 1'b1, 4'd2,  3'b100, 1'b1},
        {3'd1, 4'd2,  3'b011, 1'b1, 4'd2,  3'b100, 1'b1},
        {3'd1, 4'd2,  3'b100, 1'b1, 4'd5,  3'b010, 1'b1},
        {3'd3, 4'd5,  3'b010, 1'b1, 4'd9,  3'b001, 1'b1},
        {3'd4, 4'd9,  3'b000, 1'b0, 4'd0,  3'b000, 1'b0},
        {3'd0, 4'd11, 3'b111, 1'b0, 4'd0,  3'b000, 1'b0},
        {3'd2, 4'd11, 3'b001, 1'b1, 4'd11, 3'b111, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] ev_done = '0, ev_err = '0, ev_susp = '0, ch_rst = '0;
    logic fclr_we = 1'b0, ien_set_we = 1'b0, ien_clr_we = 1'b0;
    logic [CW-1:0] fclr_ch = '0, ien_set_ch = '0, ien_clr_ch = '0;
    logic [2:0] fclr_mask = '0, ien_set_mask = '0, ien_clr_mask = '0;
    logic [3*N-1:0] flag_view, en_view;
    logic [N-1:0] chan_pend;
    logic low_valid, irq;
    logic [CW-1:0] low_ch;
    logic [2:0] low_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_agg #(.NUM_CH(N)) u_dma_irq_agg (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_err(ev_err),
        .ev_susp(ev_susp), .ch_rst(ch_rst), .fclr_we(fclr_we), .fclr_ch(fclr_ch),
        .fclr_mask(fclr_mask), .ien_set_we(ien_set_we), .ien_set_ch(ien_set_ch),
        .ien_set_mask(ien_set_mask), .ien_clr_we(ien_clr_we), .ien_clr_ch(ien_clr_ch),
        .ien_clr_mask(ien_clr_mask), .flag_view(flag_view), .en_view(en_view),
        .chan_pend(chan_pend), .low_valid(low_valid), .low_ch(low_ch),
        .low_flags(low_flags), .irq(irq));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operation (already set up at negedge), take one edge, release, sample at negedge.
    task automatic edge_and_release();
        @(posedge clk);
        @(negedge clk);
        ev_done = '0; ev_err = '0; ev_susp = '0; ch_rst = '0;
        fclr_we = 1'b0; ien_set_we = 1'b0; ien_clr_we = 1'b0;
        #1;
    endtask

    task automatic setup_op(input logic [2:0] kind, input logic [CW-1:0] ch, input logic [2:0] m);
        case (kind)
            3'd0: begin ev_done[ch] = m[0]; ev_err[ch] = m[1]; ev_susp[ch] = m[2]; end
            3'd1: begin fclr_we = 1'b1; fclr_ch = ch; fclr_mask = m; end
            3'd2: begin ien_set_we = 1'b1; ien_set_ch = ch; ien_set_mask = m; end
            3'd3: begin ien_clr_we = 1'b1; ien_clr_ch = ch; ien_clr_mask = m; end
            default: ch_rst[ch] = 1'b1;
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(flag_view == '0 && en_view == '0 && !irq && !low_valid, "R10 reset state",
            {flag_view, en_view}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // Table walk: priority view and combined request after each step.
        for (int r = 0; r < ROWS; r++) begin
            logic [18:0] v;
            v = TABLE[r];
            @(negedge clk);
            setup_op(v[18:16], v[15:12], v[11:9]);
            edge_and_release();
            chk({low_valid, low_ch, low_flags} == v[8:1],
                v[8] ? "R7 table priority view" : "R8 table idle view",
                {low_valid, low_ch, low_flags}, v[8:1]);
            chk(irq == v[0] && irq == (|chan_pend), "R6 table irq", irq, v[0]);
        end

        // R11: ch5 enable cleared earlier, flag still readable, not pending.
        chk(flag_view[17:15] == 3'b010 && !chan_pend[5], "R11 flag kept after disable",
            {flag_view[17:15], chan_pend[5]}, 4'b0100);
        // R5: only channel 11 pending.
        chk(chan_pend == 12'h800, "R5 pending vector", chan_pend, 12'h800);

        // R1: suspend pulse on channel 0 sets bit 2.
        @(negedge clk); ev_susp[0] = 1'b1; edge_and_release();
        chk(flag_view[2:0] == 3'b100, "R1 suspend flag", flag_view[2:0], 3'b100);
        // R1: error pulse on channel 0 sets bit 1 too.
        @(negedge clk); ev_err[0] = 1'b1; edge_and_release();
        chk(flag_view[2:0] == 3'b110, "R1 error flag", flag_view[2:0], 3'b110);

        // R2: zero mask does nothing, one bit clears only that bit.
        @(negedge clk); setup_op(3'd1, 4'd11, 3'b000); edge_and_release();
        chk(flag_view[35:33] == 3'b111, "R2 zero mask no effect", flag_view[35:33], 3'b111);
        @(negedge clk); setup_op(3'd1, 4'd11, 3'b010); edge_and_release();
        chk(flag_view[35:33] == 3'b101, "R2 w1c single bit", flag_view[35:33], 3'b101);

        // R3: set and clear of same flag at same edge: set wins.
        @(negedge clk); ev_done[3] = 1'b1; setup_op(3'd1, 4'd3, 3'b001); edge_and_release();
        chk(flag_view[11:9] == 3'b001, "R3 set beats clear", flag_view[11:9], 3'b001);

        // R4: enable set and clear of same bit together: clear wins.
        @(negedge clk); setup_op(3'd2, 4'd3, 3'b001); setup_op(3'd3, 4'd3, 3'b001); edge_and_release();
        chk(en_view[11:9] == 3'b000 && !chan_pend[3], "R4 clear beats set", en_view[11:9], 3'b000);
        @(negedge clk); setup_op(3'd2, 4'd3, 3'b001); edge_and_release();
        chk(en_view[11:9] == 3'b001, "R4 enable set", en_view[11:9], 3'b001);
        chk(low_valid && low_ch == 4'd3 && low_flags == 3'b001, "R7 ch3 ahead of ch11",
            {low_valid, low_ch, low_flags}, {1'b1, 4'd3, 3'b001});

        // R9: channel reset beats an event at the same edge; channel 11 untouched.
        @(negedge clk); ch_rst[3] = 1'b1; ev_err[3] = 1'b1; edge_and_release();
        chk(flag_view[11:9] == 3'b000 && en_view[11:9] == 3'b000, "R9 channel reset",
            {flag_view[11:9], en_view[11:9]}, 6'b0);
        chk(flag_view[35:33] == 3'b101 && en_view[35:33] == 3'b001, "R9 other channel kept",
            {flag_view[35:33], en_view[35:33]}, 6'b101001);
        chk(low_ch == 4'd11 && irq, "R7 falls back to ch11", low_ch, 4'd11);

        // R10: mid-run global reset clears everything.
        @(negedge clk); rst_n = 1'b0; edge_and_release();
        rst_n = 1'b1;
        chk(flag_view == '0 && en_view == '0 && !irq, "R10 global reset",
            {flag_view, en_view}, 0);
        chk(!low_valid && low_ch == '0 && low_flags == '0, "R8 idle after reset",
            {low_valid, low_ch, low_flags}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule